// File: doc/BRIEF.md
# Processor-Host Mailbox Interrupt Registers

This block is a small mailbox between an embedded processor and a host. The processor sees three 16-bit read/write registers on its local register bus. Their contents appear to the host as six read-only bytes, so firmware can publish status to the host without the host ever writing into processor space.

The first register also carries the interrupt handshakes in both directions. A host strobe marks a host-to-processor interrupt as pending. That flag stays set until firmware writes a one to its bit, and it only reaches the processor interrupt line while the enable bit is set. In the other direction, firmware raises a request bit that drives the host interrupt output, and the host's acknowledge strobe clears that bit. Everything runs on one clock, and reads return data in the same cycle as the select.

Top module: `proc_host_mailbox`

## Requirements
- R1: After reset, all three registers read 0x0000, both interrupt outputs are low and all six host bytes are 0x00.
- R2: The registers decode at byte addresses BASE_ADDR, BASE_ADDR+4 and BASE_ADDR+8 (default 0x800000, 0x800004, 0x800008). In the second and third registers all 16 bits are read/write. In the first register, bits 15..4 and the enable bit 1 are read/write.
- R3: Bit 3 of the first register is the pending flag. A one-cycle `hostIrqReq` sets it. A processor write with bit 3 = 1 clears it. A write with bit 3 = 0 leaves it unchanged, and a write can never set it.
- R4: `irqToProc` is high exactly while both the pending flag and the enable bit 1 are 1. A host request that arrives while the enable bit is 0 still sets the pending flag.
- R5: If `hostIrqReq` and a processor write of 1 to bit 3 occur in the same cycle, the pending flag ends up at 1.
- R6: Bit 2 of the first register takes the written value and drives `irqToHost`. A `hostAck` cycle with no write to the first register clears it.
- R7: If `hostAck` and a processor write of 1 to bit 2 occur in the same cycle, bit 2 stays 1.
- R8: Host byte k (`hostMirror[k]`, k = 0..5) always equals byte k%2 of register k/2: 0 = reg0[7:0], 1 = reg0[15:8], 2 = reg1[7:0], 3 = reg1[15:8], 4 = reg2[7:0], 5 = reg2[15:8].
- R9: Any other address reads 0x0000. Writes to any other address change no register and no output.
- R10: Bit 0 of the first register always reads 0. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rstN | input | 1 | Asynchronous active-low reset |
| procSel | input | 1 | Processor bus access in this cycle |
| procWe | input | 1 | 1 = write, 0 = read |
| procAddr | input | ADDR_W (24) | Processor byte address |
| procWdata | input | DATA_W (16) | Write data |
| procRdata | output | DATA_W (16) | Read data, valid in the cycle of the select |
| hostIrqReq | input | 1 | One-cycle host request to interrupt the processor |
| hostAck | input | 1 | One-cycle host acknowledge of the processor request |
| irqToProc | output | 1 | Interrupt to the processor |
| irqToHost | output | 1 | Interrupt to the host |
| hostMirror | output | NUM_REGS*2 x 8 (48) | Host-readable byte views of the registers |

## Verification
The assertions assume that `hostIrqReq`, `hostAck`, `procSel`, `procWe`, `procAddr` and `procWdata` are synchronous to `clk` and stable around its rising edge. They also assume that every cycle in which a strobe is high counts as one event. The bench drives all inputs on the falling edge and holds each host strobe for exactly one cycle. It produces the collisions of interest (request against clear, acknowledge against write) by raising the strobe in the same cycle as the bus write. Reads are sampled shortly after the falling edge, once the combinational read path has settled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Bit positions inside the first (control) register
  localparam int PEND_BIT = 3;
  localparam int REQ_BIT  = 2;
  localparam int EN_BIT   = 1;
  localparam int GP_LO    = 4;

  // Interrupt events passed from control to datapath
  typedef struct packed {
    logic setPend;   // host asked to interrupt the processor
    logic clrPend;   // firmware wrote 1 to the pending bit
    logic ackReq;    // host acknowledged the processor request
  } ctlStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_REGS  = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h800000,
  parameter int STRIDE    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                procSel,
  input  logic                procWe,
  input  logic [ADDR_W-1:0]   procAddr,
  input  logic                pendBitVal,
  input  logic                hostIrqReq,
  input  logic                hostAck,
  output logic [NUM_REGS-1:0] wrSel,
  output logic [NUM_REGS-1:0] rdSel,
  output ctlStrobes_t         strobes
);
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(i * STRIDE);
    assign hit[i]   = procSel && (procAddr == REG_ADDR);
    assign wrSel[i] = hit[i] && procWe;
    assign rdSel[i] = hit[i] && !procWe;
  end

  always_comb begin
    strobes.setPend = hostIrqReq;
    strobes.clrPend = wrSel[0] && pendBitVal;
    strobes.ackReq  = hostAck;
  end

  // R2 / R9: at most one register selected per access
  p_single_decode_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrSel | rdSel));
  // R9: nothing selected without a bus access
  p_idle_no_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    !procSel |-> (wrSel == '0 && rdSel == '0));
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 3,
  localparam int NUM_BYTES = NUM_REGS * DATA_W / 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REGS-1:0]        wrSel,
  input  logic [NUM_REGS-1:0]        rdSel,
  input  ctlStrobes_t                strobes,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       irqToProc,
  output logic                       irqToHost,
  output logic [NUM_BYTES-1:0][7:0]  hostMirror
);
  logic [DATA_W-1:GP_LO] gpQ;
  logic pendQ, reqQ, enQ;
  logic [DATA_W-1:0] plainQ [1:NUM_REGS-1];
  logic [NUM_REGS-1:0][DATA_W-1:0] regVal;

  // Control register: general bits, enable, and the two interrupt flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpQ   <= '0;
      enQ   <= 1'b0;
      pendQ <= 1'b0;
      reqQ  <= 1'b0;
    end else begin
      if (wrSel[0]) begin
        gpQ <= wdata[DATA_W-1:GP_LO];
        enQ <= wdata[EN_BIT];
      end
      // Host set has priority over firmware clear
      if (strobes.setPend)      pendQ <= 1'b1;
      else if (strobes.clrPend) pendQ <= 1'b0;
      // Firmware write has priority over host acknowledge
      if (wrSel[0])             reqQ <= wdata[REQ_BIT];
      else if (strobes.ackReq)  reqQ <= 1'b0;
    end
  end

  // Plain general-purpose registers
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         plainQ[i] <= '0;
      else if (wrSel[i]) plainQ[i] <= wdata;
    end
    assign regVal[i] = plainQ[i];

    // R9: register holds when not written
    p_plain_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !wrSel[i] |=> $stable(plainQ[i]));
  end

  always_comb begin
    regVal[0]          = '0;
    regVal[0][DATA_W-1:GP_LO] = gpQ;
    regVal[0][PEND_BIT] = pendQ;
    regVal[0][REQ_BIT]  = reqQ;
    regVal[0][EN_BIT]   = enQ;
  end

  // Read multiplexer, zero when nothing selected
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdSel[i]) rdata = rdata | regVal[i];
    end
  end

  // Host byte views
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_mirror
    assign hostMirror[k] = regVal[k / 2][(k % 2) * 8 +: 8];
  end

  assign irqToProc = pendQ && enQ;
  assign irqToHost = reqQ;

  // R3: host request always leaves the flag set
  p_req_sets_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setPend |=> pendQ);
  // R3: clear without competing request drops the flag
  p_clear_drops_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrPend && !strobes.setPend) |=> !pendQ);
  // R3: flag can only rise through a host request
  p_pend_rise_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && !strobes.setPend) |=> !pendQ);
  // R6: acknowledge without a write drops the request
  p_ack_drops_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackReq && !wrSel[0]) |=> !irqToHost);
  // R7: writing 1 always raises the host interrupt, even with acknowledge
  p_write_beats_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel[0] && wdata[REQ_BIT]) |=> irqToHost);
  // R9: control bits hold when not written
  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrSel[0] |=> ($stable(gpQ) && $stable(enQ)));
  // R10: reserved bit never seen by the host
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostMirror[0][0] == 1'b0);
endmodule

// File: rtl/proc_host_mailbox.sv
module proc_host_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h800000,
  parameter int STRIDE    = 4,
  localparam int NUM_BYTES = NUM_REGS * DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      procSel,
  input  logic                      procWe,
  input  logic [ADDR_W-1:0]         procAddr,
  input  logic [DATA_W-1:0]         procWdata,
  output logic [DATA_W-1:0]         procRdata,
  input  logic                      hostIrqReq,
  input  logic                      hostAck,
  output logic                      irqToProc,
  output logic                      irqToHost,
  output logic [NUM_BYTES-1:0][7:0] hostMirror
);
  logic [NUM_REGS-1:0] wrSel;
  logic [NUM_REGS-1:0] rdSel;
  ctlStrobes_t strobes;

  mbox_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .procSel(procSel), .procWe(procWe), .procAddr(procAddr),
    .pendBitVal(procWdata[PEND_BIT]),
    .hostIrqReq(hostIrqReq), .hostAck(hostAck),
    .wrSel(wrSel), .rdSel(rdSel), .strobes(strobes)
  );

  mbox_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrSel(wrSel), .rdSel(rdSel), .strobes(strobes),
    .wdata(procWdata), .rdata(procRdata),
    .irqToProc(irqToProc), .irqToHost(irqToHost),
    .hostMirror(hostMirror)
  );

  // R4: processor interrupt only while enabled and pending
  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqToProc |-> (hostMirror[0][EN_BIT] && hostMirror[0][PEND_BIT]));
endmodule

// File: tb/proc_host_mailbox_test.sv
module proc_host_mailbox_test;
  localparam logic [23:0] A0 = 24'h800000;
  localparam logic [23:0] A1 = 24'h800004;
  localparam logic [23:0] A2 = 24'h800008;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procSel = 1'b0, procWe = 1'b0;
  logic [23:0] procAddr = '0;
  logic [15:0] procWdata = '0;
  logic [15:0] procRdata;
  logic hostIrqReq = 1'b0, hostAck = 1'b0;
  logic irqToProc, irqToHost;
  logic [5:0][7:0] hostMirror;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  proc_host_mailbox uut (
    .clk(clk), .rstN(rstN), .procSel(procSel), .procWe(procWe),
    .procAddr(procAddr), .procWdata(procWdata), .procRdata(procRdata),
    .hostIrqReq(hostIrqReq), .hostAck(hostAck),
    .irqToProc(irqToProc), .irqToHost(irqToHost), .hostMirror(hostMirror)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle, optionally with host strobes in the same cycle
  task automatic busWrite(logic [23:0] a, logic [15:0] d, logic req, logic ack);
    @(negedge clk);
    procSel = 1'b1; procWe = 1'b1; procAddr = a; procWdata = d;
    hostIrqReq = req; hostAck = ack;
    @(negedge clk);
    procSel = 1'b0; procWe = 1'b0; hostIrqReq = 1'b0; hostAck = 1'b0;
  endtask

  task automatic hostPulse(logic req, logic ack);
    @(negedge clk);
    hostIrqReq = req; hostAck = ack;
    @(negedge clk);
    hostIrqReq = 1'b0; hostAck = 1'b0;
  endtask

  task automatic readChk(string req, logic [23:0] a, logic [15:0] exp);
    @(negedge clk);
    procSel = 1'b1; procWe = 1'b0; procAddr = a;
    #1;
    chk(req, 32'(procRdata), 32'(exp));
    @(negedge clk);
    procSel = 1'b0;
  endtask

  task automatic tReset();
    readChk("R1 reg0", A0, 16'h0000);
    readChk("R1 reg1", A1, 16'h0000);
    readChk("R1 reg2", A2, 16'h0000);
    chk("R1 irqToProc", 32'(irqToProc), 0);
    chk("R1 irqToHost", 32'(irqToHost), 0);
    chk("R1 mirrors", 32'(hostMirror[3:0]), 0);
    chk("R1 mirrors hi", 32'(hostMirror[5:4]), 0);
  endtask

  task automatic tReadWrite();
    busWrite(A1, 16'hA55A, 1'b0, 1'b0);
    busWrite(A2, 16'h1234, 1'b0, 1'b0);
    readChk("R2 reg1", A1, 16'hA55A);
    readChk("R2 reg2", A2, 16'h1234);
    chk("R8 byte2", 32'(hostMirror[2]), 32'h5A);
    chk("R8 byte3", 32'(hostMirror[3]), 32'hA5);
    chk("R8 byte4", 32'(hostMirror[4]), 32'h34);
    chk("R8 byte5", 32'(hostMirror[5]), 32'h12);
    busWrite(A0, 16'hFFFF, 1'b0, 1'b0);
    readChk("R10 reg0 all ones", A0, 16'hFFF6);
    chk("R8 byte0", 32'(hostMirror[0]), 32'hF6);
    chk("R8 byte1", 32'(hostMirror[1]), 32'hFF);
    chk("R6 irqToHost set", 32'(irqToHost), 1);
    busWrite(A0, 16'h0000, 1'b0, 1'b0);
    readChk("R2 reg0 cleared", A0, 16'h0000);
  endtask

  task automatic tPending();
    hostPulse(1'b1, 1'b0);
    readChk("R4 pending while disabled", A0, 16'h0008);
    chk("R4 irq gated off", 32'(irqToProc), 0);
    busWrite(A0, 16'h0002, 1'b0, 1'b0);
    readChk("R3 write 0 keeps pending", A0, 16'h000A);
    chk("R4 irq on when enabled", 32'(irqToProc), 1);
    busWrite(A0, 16'h000A, 1'b0, 1'b0);
    readChk("R3 write 1 clears pending", A0, 16'h0002);
    chk("R4 irq off after clear", 32'(irqToProc), 0);
    busWrite(A0, 16'h000A, 1'b0, 1'b0);
    readChk("R3 write cannot set", A0, 16'h0002);
  endtask

  task automatic tCollide();
    hostPulse(1'b1, 1'b0);
    busWrite(A0, 16'h000A, 1'b1, 1'b0);
    readChk("R5 set beats clear", A0, 16'h000A);
    chk("R5 irq stays", 32'(irqToProc), 1);
    busWrite(A0, 16'h0008, 1'b0, 1'b0);
    readChk("R3 cleared and disabled", A0, 16'h0000);
  endtask

  task automatic tHostIrq();
    busWrite(A0, 16'h0004, 1'b0, 1'b0);
    chk("R6 request raised", 32'(irqToHost), 1);
    hostPulse(1'b0, 1'b1);
    chk("R6 ack clears", 32'(irqToHost), 0);
    readChk("R6 bit2 cleared", A0, 16'h0000);
    busWrite(A0, 16'h0004, 1'b0, 1'b1);
    chk("R7 write beats ack", 32'(irqToHost), 1);
    hostPulse(1'b0, 1'b1);
    chk("R6 second ack clears", 32'(irqToHost), 0);
  endtask

  task automatic tUnmapped();
    busWrite(A2 + 24'd4, 16'hFFFF, 1'b0, 1'b0);
    busWrite(24'h000000, 16'hFFFF, 1'b0, 1'b0);
    busWrite(A0 + 24'd2, 16'hFFFF, 1'b0, 1'b0);
    readChk("R9 unmapped read", A2 + 24'd4, 16'h0000);
    readChk("R9 odd offset read", A0 + 24'd2, 16'h0000);
    readChk("R9 reg0 untouched", A0, 16'h0000);
    readChk("R9 reg1 untouched", A1, 16'hA55A);
    readChk("R9 reg2 untouched", A2, 16'h1234);
    chk("R9 irqToHost untouched", 32'(irqToHost), 0);
    chk("R9 irqToProc untouched", 32'(irqToProc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tReadWrite();
    tPending();
    tCollide();
    tHostIrq();
    tUnmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule